// File: doc/BRIEF.md
# Matrix Least-Recently-Served Arbiter

This block picks one winner per clock cycle from a set of requesters. The rule is least recently served: a requester that has just won drops to the bottom of the order, and every other requester keeps its place relative to the rest. The order is not held as a rotating pointer. It is held as a set of pairwise precedence bits, one for each unordered pair of requesters, so the storage grows as N·(N−1)/2 flops.

The grant is combinational from the request vector, the enable and the stored precedence bits. A requester wins when it is requesting and no other active requester outranks it. At the clock edge that ends a cycle with a grant, the precedence bits move the winner below all of its peers. In a cycle with no grant the stored bits stay as they are.

A typical use is a switch or buffer allocator in an on-chip router. Each input asserts its request bit, the resource owner drives the enable, and the one-hot grant selects the input that is served. The number of requesters is a parameter with a legal range of 2 to 8.

The block has no sequencing states. Its only state is the precedence matrix. There are two transitions: hold when no grant is issued, and demote-the-winner when one is.

Top module: `lrs_matrix_arb`

## Requirements
- R1: `gnt` has at most one bit set in every cycle.
- R2: `gnt` is all zero whenever `en` is low or `req` is all zero.
- R3: A bit of `gnt` is set only when the matching bit of `req` is set.
- R4: After reset the order is by index, and index 0 is highest. With all inputs requesting and `en` high, the first grant goes to index 0.
- R5: At the clock edge after requester k is granted, k falls below every other requester. If k and any other requester both request in the next cycle, k loses.
- R6: A grant changes only the position of the winner. The relative order of all the other requesters is kept, so every grant goes to the active requester that was served longest ago, with ties broken by the order after reset.
- R7: In a cycle with no grant (because `en` is low or no request is present), the precedence state is unchanged. The next grant is the one that would have been issued without that cycle.
- R8: A lone active requester is granted in the same cycle, whatever its stored precedence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset of the precedence state |
| en | input | 1 | Allows a grant in this cycle |
| req | input | NREQ | One bit per requester, high when requesting |
| gnt | output | NREQ | One-hot grant, combinational from the inputs and the state |

## Verification
Two things can happen in the same cycle: the current grant is issued, and the precedence update is committed for that grant while the just-served requester keeps its request raised. This comes up whenever all inputs request continuously. The bench holds every request high across many cycles and expects the grant to step through each index in turn, never granting the same index twice in a row. The bench also mixes in cycles with the enable low. There it expects a zero grant, and the grant that follows must match a reference ordering list that ignored those cycles.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;

    // Number of stored precedence bits for n requesters.
    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    // Flat index of the bit for the pair (lo, hi), where lo < hi.
    function automatic int pair_index(input int lo, input int hi, input int n);
        return lo * n - (lo * (lo + 1)) / 2 + (hi - lo - 1);
    endfunction

endpackage

// File: rtl/lrs_prio_store.sv
module lrs_prio_store #(
    parameter int NREQ = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NREQ-1:0]            gnt,
    output logic [NREQ-1:0][NREQ-1:0]  prio
);
    import lrs_arb_pkg::*;

    localparam int NPAIR = pair_count(NREQ);

    logic [NPAIR-1:0] pbits;
    logic [NPAIR-1:0] pbits_nxt;

    // Row of the winner goes to 0, column of the winner goes to 1.
    always_comb begin
        pbits_nxt = pbits;
        for (int lo = 0; lo < NREQ; lo++) begin
            for (int hi = lo + 1; hi < NREQ; hi++) begin
                if (gnt[lo]) begin
                    pbits_nxt[pair_index(lo, hi, NREQ)] = 1'b0;
                end else if (gnt[hi]) begin
                    pbits_nxt[pair_index(lo, hi, NREQ)] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pbits <= '1;
        end else if (|gnt) begin
            pbits <= pbits_nxt;
        end
    end

    // Expand the triangle into a full matrix: prio[a][b] means a outranks b.
    for (genvar a = 0; a < NREQ; a++) begin : g_row
        for (genvar b = 0; b < NREQ; b++) begin : g_col
            if (a < b) begin : g_upper
                assign prio[a][b] = pbits[pair_index(a, b, NREQ)];
            end else if (a > b) begin : g_lower
                assign prio[a][b] = ~pbits[pair_index(b, a, NREQ)];
            end else begin : g_diag
                assign prio[a][b] = 1'b0;
            end
        end
    end

    // R7: no grant, no change to the stored order
    assert_hold_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|gnt) |=> $stable(pbits));

endmodule

// File: rtl/lrs_grant_logic.sv
module lrs_grant_logic #(
    parameter int NREQ = 4
) (
    input  logic                       en,
    input  logic [NREQ-1:0]            req,
    input  logic [NREQ-1:0][NREQ-1:0]  prio,
    output logic [NREQ-1:0]            gnt
);
    logic [NREQ-1:0] blocked;

    for (genvar c = 0; c < NREQ; c++) begin : g_cand
        logic [NREQ-1:0] beaters;
        for (genvar o = 0; o < NREQ; o++) begin : g_other
            assign beaters[o] = prio[o][c];
        end
        assign blocked[c] = |(req & beaters);
        assign gnt[c]     = en & req[c] & ~blocked[c];
    end

endmodule

// File: rtl/lrs_matrix_arb.sv
module lrs_matrix_arb #(
    parameter int NREQ = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NREQ-1:0] req,
    output logic [NREQ-1:0] gnt
);
    logic [NREQ-1:0][NREQ-1:0] prio;

    lrs_prio_store #(.NREQ(NREQ)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .gnt   (gnt),
        .prio  (prio)
    );

    lrs_grant_logic #(.NREQ(NREQ)) u_grant (
        .en   (en),
        .req  (req),
        .prio (prio),
        .gnt  (gnt)
    );

    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || req == '0) |-> gnt == '0);

    assert_granted_requests_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    // R8: a lone requester always wins when enabled
    assert_lone_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $onehot(req)) |-> gnt == req);

    // R5: the winner outranks nobody once the update lands
    for (genvar k = 0; k < NREQ; k++) begin : g_demote
        assert_demote_R5: assert property (@(posedge clk) disable iff (!rst_n)
            gnt[k] |=> prio[k] == '0);
    end

endmodule

// File: tb/tb_lrs_matrix_arb.sv
module tb_lrs_matrix_arb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] gnt;

    int n_chk = 0;
    int n_bad = 0;
    int ord[N];          // ord[0] is the highest-ranked requester
    logic [7:0] lfsr = 8'hA5;

    lrs_matrix_arb #(.NREQ(N)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .req(req), .gnt(gnt)
    );

    always #5 clk = ~clk;

    task automatic chk(input string rid, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt actual %b expected %b", rid, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) ord[i] = i;
    endtask

    function automatic logic [N-1:0] model_gnt(input logic e, input logic [N-1:0] r);
        logic [N-1:0] g = '0;
        if (e) begin
            for (int p = 0; p < N; p++) begin
                if (r[ord[p]]) begin
                    g[ord[p]] = 1'b1;
                    break;
                end
            end
        end
        return g;
    endfunction

    task automatic model_commit(input logic [N-1:0] g);
        int pos = -1;
        int w = 0;
        for (int p = 0; p < N; p++) if (g[ord[p]]) pos = p;
        if (pos >= 0) begin
            w = ord[pos];
            for (int p = pos; p < N - 1; p++) ord[p] = ord[p + 1];
            ord[N - 1] = w;
        end
    endtask

    // Drive at the falling edge, check 2 ns later, state moves at the next rise.
    task automatic step(input string rid, input logic e, input logic [N-1:0] r);
        logic [N-1:0] exp;
        @(negedge clk);
        en = e;
        req = r;
        #2;
        exp = model_gnt(e, r);
        chk(rid, gnt, exp);
        n_chk++;
        if ($countones(gnt) > 1) begin
            n_bad++;
            $display("FAIL R1: gnt actual %b expected at most one bit", gnt);
        end
        n_chk++;
        if ((gnt & ~r) != '0) begin
            n_bad++;
            $display("FAIL R3: gnt actual %b expected within req %b", gnt, r);
        end
        model_commit(exp);
    endtask

    task automatic t_reset();
        model_reset();
        #2;
        chk("R2_reset", gnt, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R2_noreq", 1'b1, '0);
        step("R4_first", 1'b1, '1);
        chk("R4_idx0", gnt, 4'b0001);
    endtask

    task automatic t_rotate();
        for (int c = 0; c < 3 * N; c++) begin
            step("R5_rotate", 1'b1, '1);
            chk("R5_order", gnt, N'(1) << ((c + 1) % N));
        end
    endtask

    task automatic t_enable_low();
        step("R2_en_low", 1'b0, '1);
        chk("R2_en_low_zero", gnt, '0);
        step("R7_after_hold", 1'b1, '1);
        step("R7_norq", 1'b1, '0);
        step("R7_after_idle", 1'b1, 4'b1111);
    endtask

    task automatic t_lone();
        for (int i = 0; i < N; i++) begin
            step("R8_lone", 1'b1, N'(1) << i);
            chk("R8_lone_bit", gnt, N'(1) << i);
        end
    endtask

    task automatic t_pair_order();
        step("R6_pair_a", 1'b1, 4'b0101);
        step("R6_pair_b", 1'b1, 4'b0101);
        step("R6_mix", 1'b1, 4'b1110);
        step("R6_mix2", 1'b1, 4'b1011);
    endtask

    task automatic t_random();
        for (int c = 0; c < 300; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step("R6_random", (lfsr[7] | lfsr[6]), lfsr[N-1:0]);
        end
    endtask

    initial begin
        t_reset();
        t_rotate();
        t_enable_low();
        t_lone();
        t_pair_order();
        t_random();
        @(negedge clk);
        en = 1'b0;
        req = '0;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule